// File: doc/BRIEF.md
# Port Interrupt-on-Change Controller

This block watches a parallel input port and raises one interrupt line when an enabled pin meets its trigger condition. Each pin picks its trigger on its own. In change mode the pin fires when its value differs from the value it had one cycle earlier. In default mode it fires while its value differs from a programmed reference bit. The raw pins pass through a multi-stage synchroniser before any comparison. The controller also provides a copy of the port with a per-bit polarity inversion applied.

When the first event fires, the block records which pins caused it as a set of per-pin flags. It also records a snapshot of the synchronised port in a capture register. Both stay frozen while the interrupt is pending, so later activity cannot overwrite the recorded cause. Software ends the pending state with a read strobe on either the capture register or the port. The interrupt line can be set to active-low, active-high or open-drain.

Top module: `ioc_irq_ctrl`

## Requirements
- R1: While reset is low at a rising edge, and after it, the flags and the capture register read zero and the interrupt is deasserted. Reset may be applied at any time.
- R2: A pin change reaches `port_o` after exactly two rising edges. It reaches `flags_o` after exactly three.
- R3: An enabled pin whose `mode_sel` bit is 0 sets its flag when its synchronised value differs from its value one cycle earlier.
- R4: An enabled pin whose `mode_sel` bit is 1 sets its flag when its synchronised value differs from its bit of `dflt_val`.
- R5: A pin whose `pin_en` bit is 0 never sets its flag, whatever its mode or activity.
- R6: When the flags go from all-zero to non-zero, `cap_o` takes the raw synchronised port value (no inversion) from the cycle in which the trigger was seen.
- R7: While any flag is set and no read strobe is given, `flags_o` and `cap_o` hold their values, even if further enabled pins trigger.
- R8: A high `cap_rd` or `port_rd` clears all flags at the next edge. The clear beats an event seen in the same cycle, and that event is dropped. `cap_o` keeps its value.
- R9: In default mode, a mismatch that is still present sets the flag again one edge after the clearing edge.
- R10: `port_o` equals the synchronised pins XOR `invert`, bit by bit.
- R11: With `irq_odrain` 0, `irq_oe_o` is 1. `irq_level_o` is the pending state when `irq_pol` is 1, and its inverse when `irq_pol` is 0.
- R12: With `irq_odrain` 1, `irq_level_o` is 0 and `irq_oe_o` equals the pending state, whatever `irq_pol` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | WIDTH | Raw port pins |
| pin_en | input | WIDTH | Per-pin interrupt enable |
| mode_sel | input | WIDTH | Per-pin trigger: 0 change, 1 compare with default |
| dflt_val | input | WIDTH | Reference values for default mode |
| invert | input | WIDTH | Per-bit inversion for `port_o` |
| irq_pol | input | 1 | 1 active-high, 0 active-low (push-pull) |
| irq_odrain | input | 1 | 1 selects open-drain drive |
| cap_rd | input | 1 | Capture-register read strobe, clears pending |
| port_rd | input | 1 | Port read strobe, clears pending |
| flags_o | output | WIDTH | Pins that caused the pending interrupt |
| cap_o | output | WIDTH | Port snapshot taken when the interrupt fired |
| port_o | output | WIDTH | Polarity-adjusted synchronised port |
| irq_level_o | output | 1 | Interrupt pin level |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
The bench builds the block with its defaults: eight pins and a two-stage synchroniser. Eight pins allow whole-byte patterns that mix change-mode and default-mode pins, and enabled and disabled pins, in a single stimulus. The two-stage depth makes the two-edge port latency and the three-edge flag latency exact cycle counts. With that latency fixed, the bench can land a read strobe in the very cycle an event is detected and show that the event is dropped.

// File: rtl/ioc_pkg.sv
// Shared types for the interrupt-on-change controller.
// Assumes nothing beyond being compiled before the modules that import it.
package ioc_pkg;

    // Drive style of the interrupt pin
    typedef enum logic [1:0] {
        DRV_ACT_LOW   = 2'd0,
        DRV_ACT_HIGH  = 2'd1,
        DRV_OPEN_DRN  = 2'd2
    } drive_e;

    // Open-drain overrides polarity
    function automatic drive_e drive_decode(input logic odrain, input logic pol);
        if (odrain)
            return DRV_OPEN_DRN;
        else if (pol)
            return DRV_ACT_HIGH;
        else
            return DRV_ACT_LOW;
    endfunction

endpackage

// File: rtl/ioc_sync.sv
// Multi-stage synchroniser for the raw port pins.
// Assumes STAGES >= 1. Every stage resets to zero synchronously.
module ioc_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage samples the asynchronous pins
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q[0] <= '0;
        else
            stage_q[0] <= d_i;
    end

    // Remaining stages form the resolution chain
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage_q[g] <= '0;
            else
                stage_q[g] <= stage_q[g-1];
        end
    end

    assign q_o = stage_q[LAST];

endmodule

// File: rtl/ioc_detect.sv
// Per-pin trigger detector.
// Keeps the previous synchronised value and produces a combinational
// hit vector: change mode compares with the previous cycle, default
// mode compares with the reference bit. Disabled pins never hit.
module ioc_detect #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_i,
    input  logic [WIDTH-1:0] en_i,
    input  logic [WIDTH-1:0] mode_i,
    input  logic [WIDTH-1:0] dflt_i,
    output logic [WIDTH-1:0] hit_o
);

    logic [WIDTH-1:0] prev_q;

    // Previous-cycle copy of the synchronised port
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= '0;
        else
            prev_q <= sync_i;
    end

    // Per-pin trigger selection
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic ref_bit;
        always_comb begin
            ref_bit  = mode_i[i] ? dflt_i[i] : prev_q[i];
            hit_o[i] = en_i[i] & (sync_i[i] ^ ref_bit);
        end
    end

endmodule

// File: rtl/ioc_flag_cap.sv
// Flag and capture registers.
// Loads the hit vector and a port snapshot only when nothing is pending.
// A read strobe clears the flags and wins over a same-cycle hit.
// The capture value survives the clear.
module ioc_flag_cap #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] hit_i,
    input  logic [WIDTH-1:0] sync_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] flags_o,
    output logic [WIDTH-1:0] cap_o,
    output logic             pend_o
);

    logic any_hit;

    // Any enabled pin triggered this cycle
    assign any_hit = |hit_i;
    assign pend_o  = |flags_o;

    // Flags: clear first, otherwise load only when idle
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_o <= '0;
        else if (clr_i)
            flags_o <= '0;
        else if (!pend_o && any_hit)
            flags_o <= hit_i;
    end

    // Capture: snapshot taken together with the flag load
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_o <= '0;
        else if (!clr_i && !pend_o && any_hit)
            cap_o <= sync_i;
    end

endmodule

// File: rtl/ioc_irq_drive.sv
// Interrupt pin driver.
// Turns the pending state into a pin level and output enable.
// Purely combinational.
module ioc_irq_drive
    import ioc_pkg::*;
(
    input  logic pend_i,
    input  logic pol_i,
    input  logic odrain_i,
    output logic level_o,
    output logic oe_o
);

    drive_e mode;

    // Select the drive style, then the level and enable
    always_comb begin
        mode = drive_decode(odrain_i, pol_i);
        case (mode)
            DRV_OPEN_DRN: begin
                level_o = 1'b0;
                oe_o    = pend_i;
            end
            DRV_ACT_HIGH: begin
                level_o = pend_i;
                oe_o    = 1'b1;
            end
            default: begin
                level_o = ~pend_i;
                oe_o    = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ioc_irq_ctrl.sv
// Interrupt-on-change controller top.
// Chain: synchroniser -> detector -> flag/capture -> pin driver.
// The port output is the synchronised value with per-bit inversion.
// Configuration inputs are assumed static relative to clk.
module ioc_irq_ctrl #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] pin_en,
    input  logic [WIDTH-1:0] mode_sel,
    input  logic [WIDTH-1:0] dflt_val,
    input  logic [WIDTH-1:0] invert,
    input  logic             irq_pol,
    input  logic             irq_odrain,
    input  logic             cap_rd,
    input  logic             port_rd,
    output logic [WIDTH-1:0] flags_o,
    output logic [WIDTH-1:0] cap_o,
    output logic [WIDTH-1:0] port_o,
    output logic             irq_level_o,
    output logic             irq_oe_o
);

    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] hit;
    logic             pend;
    logic             clr;

    // Either read strobe ends the pending interrupt
    assign clr    = cap_rd | port_rd;
    assign port_o = sync_q ^ invert;

    ioc_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_in),
        .q_o   (sync_q)
    );

    ioc_detect #(.WIDTH(WIDTH)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_q),
        .en_i   (pin_en),
        .mode_i (mode_sel),
        .dflt_i (dflt_val),
        .hit_o  (hit)
    );

    ioc_flag_cap #(.WIDTH(WIDTH)) u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (hit),
        .sync_i  (sync_q),
        .clr_i   (clr),
        .flags_o (flags_o),
        .cap_o   (cap_o),
        .pend_o  (pend)
    );

    ioc_irq_drive u_drive (
        .pend_i   (pend),
        .pol_i    (irq_pol),
        .odrain_i (irq_odrain),
        .level_o  (irq_level_o),
        .oe_o     (irq_oe_o)
    );

endmodule

// File: rtl/ioc_irq_ctrl_chk.sv
// Property checker for ioc_irq_ctrl, attached by bind below.
// Watches the ports and the internal synchronised port value.
module ioc_irq_ctrl_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] pin_en,
    input logic             cap_rd,
    input logic             port_rd,
    input logic             irq_odrain,
    input logic [WIDTH-1:0] flags_o,
    input logic [WIDTH-1:0] cap_o,
    input logic [WIDTH-1:0] sync_i,
    input logic             irq_level_o,
    input logic             irq_oe_o
);

    logic pend;
    logic clr;
    assign pend = |flags_o;
    assign clr  = cap_rd | port_rd;

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> ($stable(flags_o) && $stable(cap_o)));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (flags_o == '0));

    p_keep_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> $stable(cap_o));

    p_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !clr) |=> ((flags_o & ~$past(pin_en)) == '0));

    p_snapshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !clr && (flags_o == '0)) |=> ((flags_o == '0) || (cap_o == $past(sync_i))));

    p_odrain_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_odrain |-> (!irq_level_o && (irq_oe_o == pend)));

    p_pushpull_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_odrain |-> irq_oe_o);

endmodule

bind ioc_irq_ctrl ioc_irq_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_en      (pin_en),
    .cap_rd      (cap_rd),
    .port_rd     (port_rd),
    .irq_odrain  (irq_odrain),
    .flags_o     (flags_o),
    .cap_o       (cap_o),
    .sync_i      (sync_q),
    .irq_level_o (irq_level_o),
    .irq_oe_o    (irq_oe_o)
);

// File: tb/test_ioc_irq_ctrl.sv
`timescale 1ns/1ps
module test_ioc_irq_ctrl;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] pin_in, pin_en, mode_sel, dflt_val, invert;
    logic         irq_pol, irq_odrain, cap_rd, port_rd;
    logic [W-1:0] flags_o, cap_o, port_o;
    logic         irq_level_o, irq_oe_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    ioc_irq_ctrl #(.WIDTH(W), .SYNC_STAGES(2)) i_ioc_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_en(pin_en),
        .mode_sel(mode_sel), .dflt_val(dflt_val), .invert(invert),
        .irq_pol(irq_pol), .irq_odrain(irq_odrain), .cap_rd(cap_rd),
        .port_rd(port_rd), .flags_o(flags_o), .cap_o(cap_o), .port_o(port_o),
        .irq_level_o(irq_level_o), .irq_oe_o(irq_oe_o)
    );

    // Vector: en, mode, dflt, inv, pin_before, pin_after, expected flags
    localparam logic [55:0] VEC [6] = '{
        {8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01},  // R3 single pin
        {8'h0F, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF3, 8'h03},  // R3 with R5 mask
        {8'hFF, 8'hFF, 8'hA5, 8'h00, 8'hA5, 8'hA4, 8'h01},  // R4
        {8'hF0, 8'hF0, 8'h30, 8'h00, 8'h30, 8'h3C, 8'h00},  // R5 masked mismatch
        {8'hFF, 8'h0F, 8'h05, 8'h00, 8'h05, 8'h85, 8'h80},  // R3/R4 mixed
        {8'h81, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h7E, 8'h81}   // R10 inverted port
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd_pulse();
        cap_rd = 1'b1;
        tick(1);
        cap_rd = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pin_in = '0; pin_en = '0; mode_sel = '0; dflt_val = '0;
        invert = '0; irq_pol = 1'b0; irq_odrain = 1'b0; cap_rd = 1'b0; port_rd = 1'b0;
        tick(3);
        chk("R1 flags", flags_o, 0);
        chk("R1 cap", cap_o, 0);
        chk("R1 irq level", irq_level_o, 1);
        chk("R1 irq oe", irq_oe_o, 1);
        rst_n = 1'b1;
        tick(1);

        // Vector walk
        for (int v = 0; v < 6; v++) begin
            logic [7:0] en, md, df, iv, pa, pb, ef;
            {en, md, df, iv, pa, pb, ef} = VEC[v];
            pin_en = '0; mode_sel = md; dflt_val = df; invert = iv; pin_in = pa;
            tick(4);
            rd_pulse();
            tick(1);
            pin_en = en;
            tick(1);
            pin_in = pb;
            tick(4);
            chk($sformatf("R3/R4/R5 flags vec%0d", v), flags_o, ef);
            chk($sformatf("R10 port vec%0d", v), port_o, pb ^ iv);
            chk($sformatf("R11 level vec%0d", v), irq_level_o, (ef == 0));
            if (ef != 0)
                chk($sformatf("R6 cap vec%0d", v), cap_o, pb);
        end

        // Disabled pins: no flag from activity
        pin_en = '0; mode_sel = '0; invert = '0; pin_in = '0;
        tick(4);
        rd_pulse();
        tick(1);
        pin_in = 8'hFF;
        tick(4);
        chk("R5 disabled activity", flags_o, 0);

        // Latency of port and flags
        pin_in = 8'h00;
        tick(4);
        pin_en = 8'h01;
        tick(1);
        pin_in = 8'h01;
        tick(1);
        chk("R2 port after 1 edge", port_o, 8'h00);
        tick(1);
        chk("R2 port after 2 edges", port_o, 8'h01);
        chk("R2 flags after 2 edges", flags_o, 0);
        tick(1);
        chk("R2 flags after 3 edges", flags_o, 8'h01);

        // Hold while pending
        rd_pulse();
        pin_in = 8'h00; pin_en = 8'h00;
        tick(4);
        pin_en = 8'h03;
        tick(1);
        pin_in = 8'h01;
        tick(4);
        chk("R3 first event flags", flags_o, 8'h01);
        chk("R6 first event cap", cap_o, 8'h01);
        pin_in = 8'h03;
        tick(4);
        chk("R7 flags held", flags_o, 8'h01);
        chk("R7 cap held", cap_o, 8'h01);

        // Clear by port read, capture kept
        port_rd = 1'b1;
        tick(1);
        port_rd = 1'b0;
        chk("R8 port read clears", flags_o, 0);
        chk("R8 cap kept", cap_o, 8'h01);
        tick(3);
        chk("R8 stays clear", flags_o, 0);

        // Clear in the same cycle as a hit drops the event
        pin_in = 8'h00;
        tick(2);
        cap_rd = 1'b1;
        tick(1);
        cap_rd = 1'b0;
        chk("R8 clear beats event", flags_o, 0);
        chk("R8 cap unchanged", cap_o, 8'h01);
        tick(3);
        chk("R8 event dropped", flags_o, 0);

        // Default-mode refire after clear
        pin_en = 8'h01; mode_sel = 8'h01; dflt_val = 8'h00;
        pin_in = 8'h01;
        tick(4);
        chk("R4 default mismatch", flags_o, 8'h01);
        rd_pulse();
        chk("R9 cleared", flags_o, 0);
        tick(1);
        chk("R9 refire", flags_o, 8'h01);

        // Output drive styles while pending
        irq_pol = 1'b0; irq_odrain = 1'b0; #1;
        chk("R11 active-low level", irq_level_o, 0);
        irq_pol = 1'b1; #1;
        chk("R11 active-high level", irq_level_o, 1);
        chk("R11 oe", irq_oe_o, 1);
        irq_odrain = 1'b1; #1;
        chk("R12 od level", irq_level_o, 0);
        chk("R12 od oe pending", irq_oe_o, 1);
        pin_in = 8'h00;
        tick(3);
        rd_pulse();
        chk("R12 od oe idle", irq_oe_o, 0);
        irq_odrain = 1'b0; #1;
        chk("R11 active-high idle", irq_level_o, 0);
        irq_pol = 1'b0;

        // Reset during a pending interrupt
        pin_in = 8'h01;
        tick(4);
        chk("R4 pending before reset", flags_o, 8'h01);
        rst_n = 1'b0;
        tick(1);
        chk("R1 reset flags", flags_o, 0);
        chk("R1 reset cap", cap_o, 0);
        rst_n = 1'b1;
        pin_en = '0;
        tick(1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule